// File: doc/BRIEF.md
# Bus Clock-Enable Prescaler Tree

This block derives every bus and peripheral timing strobe of a subsystem from one free-running system clock. It creates no new clocks. Each branch of the tree is a single-cycle enable pulse that fires once per divided period in the system clock domain. Downstream logic stays on the system clock and advances only on its own strobe.

The tree has four levels:
- A main bus divider runs straight from the system clock.
- Two peripheral-bus dividers count main-bus strobes.
- Each peripheral bus has a timer strobe that runs at the bus rate when that bus divides by 1, and at twice the bus rate otherwise.
- A converter-clock divider counts pulses of the second peripheral bus. Two fixed taps give a system-timer tick at one eighth of the main-bus rate and a storage-interface strobe at half the main-bus rate.

Ratio codes come from configuration fields. A new code is picked up only at the end of the period in progress, so a change never yields a shortened period. Per-peripheral strobes are each gated by their own enable bit. A combinational flag warns when the configured ratios, applied to the system frequency parameter, would run the first peripheral bus above 36 MHz.

Top module: `clk_prescale_tree`

## Requirements
- R1: While rst_ni is low, every strobe output (hclk_en_o, pclk1_en_o, pclk2_en_o, tim1_en_o, tim2_en_o, adc_en_o, tick_en_o, stor_en_o, apb1_dev_en_o, apb2_dev_en_o) is 0.
- R2: Main-bus code ahb_div_i: bit 3 = 0 selects divide by 1. Codes 8 through 15 select 2, 4, 8, 16, 64, 128, 256, 512 in that order, so 32 is not offered. Once settled, hclk_en_o pulses once every that many system cycles.
- R3: Peripheral-bus codes apb1_div_i and apb2_div_i: bit 2 = 0 selects divide by 1. Codes 4 through 7 select 2, 4, 8, 16. Each pclkN_en_o pulses once every (main ratio × bus ratio) system cycles.
- R4: The timer strobe timN_en_o has the same period as pclkN_en_o when that bus ratio is 1, and half that period otherwise.
- R5: Converter code adc_div_i values 0, 1, 2, 3 divide the pclk2_en_o pulse rate by 2, 4, 6, 8.
- R6: tick_en_o has a period of 8 main-bus periods. stor_en_o has a period of 2 main-bus periods.
- R7: A code change takes effect at the next end of the divided period in progress. The period running when the code changes completes at its old length, and every later period has the new length.
- R8: For each bit i, apbN_dev_en_o[i] follows pclkN_en_o when apbN_gate_i[i] = 1 and stays 0 when it is 0.
- R9: apb1_ovf_o is 1 exactly when SYS_KHZ > APB1_MAX_KHZ × main ratio × bus-1 ratio, where both ratios are decoded from the present input codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ahb_div_i | input | 4 | Main-bus ratio code |
| apb1_div_i | input | 3 | Peripheral bus 1 ratio code |
| apb2_div_i | input | 3 | Peripheral bus 2 ratio code |
| adc_div_i | input | 2 | Converter ratio code |
| apb1_gate_i | input | N_APB1_DEV | Per-device enables, bus 1 |
| apb2_gate_i | input | N_APB2_DEV | Per-device enables, bus 2 |
| hclk_en_o | output | 1 | Main-bus strobe |
| pclk1_en_o | output | 1 | Peripheral bus 1 strobe |
| pclk2_en_o | output | 1 | Peripheral bus 2 strobe |
| tim1_en_o | output | 1 | Timer strobe, bus 1 |
| tim2_en_o | output | 1 | Timer strobe, bus 2 |
| adc_en_o | output | 1 | Converter strobe |
| tick_en_o | output | 1 | System-timer tick |
| stor_en_o | output | 1 | Storage-interface strobe |
| apb1_dev_en_o | output | N_APB1_DEV | Gated device strobes, bus 1 |
| apb2_dev_en_o | output | N_APB2_DEV | Gated device strobes, bus 2 |
| apb1_ovf_o | output | 1 | Bus 1 over-frequency flag |

## Verification
The bench builds the block with SYS_KHZ = 72000, APB1_MAX_KHZ = 36000 and four gated devices per bus. At that frequency, bus 1 divided by 1 trips the flag, while a total ratio of 2 sits exactly on the limit and must not trip it. This brings both flag outcomes and the equality edge within reach. Four gate bits allow a mixed on/off pattern on each bus. Main-bus ratios are kept small enough that the nested converter and timer periods, including the divide-by-6 and the skipped-32 code, can be timed over several pulses.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;
  localparam int unsigned AHB_MAX_RATIO = 512;
  localparam int unsigned APB_MAX_RATIO = 16;
  localparam int unsigned TIM_MAX_RATIO = APB_MAX_RATIO / 2;
  localparam int unsigned ADC_MAX_RATIO = 8;
  localparam int unsigned TICK_RATIO    = 8;
  localparam int unsigned STOR_RATIO    = 2;

  function automatic int unsigned cnt_width(input int unsigned max_ratio);
    return (max_ratio > 1) ? $clog2(max_ratio) : 1;
  endfunction

  // bit3 clear: /1; otherwise 2..16 then 64..512 (no 32)
  function automatic logic [9:0] ahb_ratio(input logic [3:0] code);
    logic [9:0] r;
    if (!code[3]) r = 10'd1;
    else if (!code[2]) r = 10'd2 << code[1:0];
    else r = 10'd64 << code[1:0];
    return r;
  endfunction

  function automatic logic [4:0] apb_ratio(input logic [2:0] code);
    return code[2] ? (5'd2 << code[1:0]) : 5'd1;
  endfunction

  function automatic logic [3:0] adc_ratio(input logic [1:0] code);
    return {1'b0, code, 1'b0} + 4'd2;
  endfunction
endpackage

// File: rtl/clk_en_div.sv
module clk_en_div #(
  parameter int unsigned MAX_RATIO = 16,
  localparam int unsigned CW = clk_tree_pkg::cnt_width(MAX_RATIO)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_en_i,
  input  logic [CW-1:0] lim_i,
  output logic          out_en_o
);
  logic [CW-1:0] cnt_q, lim_q;
  logic          wrap;

  assign wrap     = in_en_i && (cnt_q == lim_q);
  assign out_en_o = wrap;

  // new limit is sampled only at the period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (in_en_i) begin
      if (wrap) begin
        cnt_q <= '0;
        lim_q <= lim_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int unsigned N = 8
) (
  input  logic         en_i,
  input  logic [N-1:0] gate_i,
  output logic [N-1:0] en_o
);
  for (genvar i = 0; i < N; i++) begin : g_gate
    assign en_o[i] = en_i & gate_i[i];
  end
endmodule

// File: rtl/clk_ovf_check.sv
module clk_ovf_check #(
  parameter int unsigned SYS_KHZ   = 72000,
  parameter int unsigned LIMIT_KHZ = 36000
) (
  input  logic [3:0] ahb_div_i,
  input  logic [2:0] apb_div_i,
  output logic       ovf_o
);
  import clk_tree_pkg::*;
  logic [63:0] floor_khz;

  always_comb begin
    floor_khz = 64'(LIMIT_KHZ) * 64'(ahb_ratio(ahb_div_i)) * 64'(apb_ratio(apb_div_i));
    ovf_o     = 64'(SYS_KHZ) > floor_khz;
  end
endmodule

// File: rtl/clk_prescale_tree.sv
module clk_prescale_tree
  import clk_tree_pkg::*;
#(
  parameter int unsigned N_APB1_DEV   = 8,
  parameter int unsigned N_APB2_DEV   = 8,
  parameter int unsigned SYS_KHZ      = 72000,
  parameter int unsigned APB1_MAX_KHZ = 36000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [3:0]            ahb_div_i,
  input  logic [2:0]            apb1_div_i,
  input  logic [2:0]            apb2_div_i,
  input  logic [1:0]            adc_div_i,
  input  logic [N_APB1_DEV-1:0] apb1_gate_i,
  input  logic [N_APB2_DEV-1:0] apb2_gate_i,
  output logic                  hclk_en_o,
  output logic                  pclk1_en_o,
  output logic                  pclk2_en_o,
  output logic                  tim1_en_o,
  output logic                  tim2_en_o,
  output logic                  adc_en_o,
  output logic                  tick_en_o,
  output logic                  stor_en_o,
  output logic [N_APB1_DEV-1:0] apb1_dev_en_o,
  output logic [N_APB2_DEV-1:0] apb2_dev_en_o,
  output logic                  apb1_ovf_o
);
  localparam int unsigned AHB_CW  = cnt_width(AHB_MAX_RATIO);
  localparam int unsigned APB_CW  = cnt_width(APB_MAX_RATIO);
  localparam int unsigned TIM_CW  = cnt_width(TIM_MAX_RATIO);
  localparam int unsigned ADC_CW  = cnt_width(ADC_MAX_RATIO);
  localparam int unsigned TICK_CW = cnt_width(TICK_RATIO);
  localparam int unsigned STOR_CW = cnt_width(STOR_RATIO);

  logic       run_q;
  logic       hclk_en;
  logic [2:0] apb_code [2];
  logic [1:0] pclk_en, tim_en;

  // holds the root quiet in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  clk_en_div #(.MAX_RATIO(AHB_MAX_RATIO)) u_ahb (
    .clk_i, .rst_ni,
    .in_en_i  (run_q),
    .lim_i    (AHB_CW'(ahb_ratio(ahb_div_i) - 10'd1)),
    .out_en_o (hclk_en)
  );

  assign apb_code[0] = apb1_div_i;
  assign apb_code[1] = apb2_div_i;

  for (genvar b = 0; b < 2; b++) begin : g_apb
    logic [4:0] ratio;
    logic [4:0] tim_ratio;
    assign ratio     = apb_ratio(apb_code[b]);
    // timer runs at 2x bus rate unless bus ratio is 1
    assign tim_ratio = (ratio == 5'd1) ? 5'd1 : (ratio >> 1);

    clk_en_div #(.MAX_RATIO(APB_MAX_RATIO)) u_bus (
      .clk_i, .rst_ni,
      .in_en_i  (hclk_en),
      .lim_i    (APB_CW'(ratio - 5'd1)),
      .out_en_o (pclk_en[b])
    );

    clk_en_div #(.MAX_RATIO(TIM_MAX_RATIO)) u_tim (
      .clk_i, .rst_ni,
      .in_en_i  (hclk_en),
      .lim_i    (TIM_CW'(tim_ratio - 5'd1)),
      .out_en_o (tim_en[b])
    );
  end

  clk_en_div #(.MAX_RATIO(ADC_MAX_RATIO)) u_adc (
    .clk_i, .rst_ni,
    .in_en_i  (pclk_en[1]),
    .lim_i    (ADC_CW'(adc_ratio(adc_div_i) - 4'd1)),
    .out_en_o (adc_en_o)
  );

  clk_en_div #(.MAX_RATIO(TICK_RATIO)) u_tick (
    .clk_i, .rst_ni,
    .in_en_i  (hclk_en),
    .lim_i    (TICK_CW'(TICK_RATIO - 1)),
    .out_en_o (tick_en_o)
  );

  clk_en_div #(.MAX_RATIO(STOR_RATIO)) u_stor (
    .clk_i, .rst_ni,
    .in_en_i  (hclk_en),
    .lim_i    (STOR_CW'(STOR_RATIO - 1)),
    .out_en_o (stor_en_o)
  );

  clk_gate_bank #(.N(N_APB1_DEV)) u_gate1 (
    .en_i (pclk_en[0]), .gate_i (apb1_gate_i), .en_o (apb1_dev_en_o)
  );

  clk_gate_bank #(.N(N_APB2_DEV)) u_gate2 (
    .en_i (pclk_en[1]), .gate_i (apb2_gate_i), .en_o (apb2_dev_en_o)
  );

  clk_ovf_check #(.SYS_KHZ(SYS_KHZ), .LIMIT_KHZ(APB1_MAX_KHZ)) u_ovf (
    .ahb_div_i (ahb_div_i),
    .apb_div_i (apb1_div_i),
    .ovf_o     (apb1_ovf_o)
  );

  assign hclk_en_o  = hclk_en;
  assign pclk1_en_o = pclk_en[0];
  assign pclk2_en_o = pclk_en[1];
  assign tim1_en_o  = tim_en[0];
  assign tim2_en_o  = tim_en[1];
endmodule

// File: rtl/clk_prescale_tree_chk.sv
module clk_prescale_tree_chk #(
  parameter int unsigned N1           = 8,
  parameter int unsigned N2           = 8,
  parameter int unsigned SYS_KHZ      = 72000,
  parameter int unsigned APB1_MAX_KHZ = 36000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    ahb_div_i,
  input logic [2:0]    apb1_div_i,
  input logic          hclk_en_o,
  input logic          pclk1_en_o,
  input logic          pclk2_en_o,
  input logic          tim1_en_o,
  input logic          tim2_en_o,
  input logic          adc_en_o,
  input logic          tick_en_o,
  input logic          stor_en_o,
  input logic [N1-1:0] apb1_dev_en_o,
  input logic [N2-1:0] apb2_dev_en_o,
  input logic          apb1_ovf_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_QUIET: assert (!(hclk_en_o | pclk1_en_o | pclk2_en_o | tim1_en_o | tim2_en_o |
                               adc_en_o | tick_en_o | stor_en_o |
                               (|apb1_dev_en_o) | (|apb2_dev_en_o))); // R1
    end
  end

  AST_PCLK1_IN_HCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk1_en_o |-> hclk_en_o); // R3
  AST_PCLK2_IN_HCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk2_en_o |-> hclk_en_o); // R3
  AST_TIM_IN_HCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tim1_en_o || tim2_en_o) |-> hclk_en_o); // R4
  AST_ADC_IN_PCLK2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_en_o |-> pclk2_en_o); // R5
  AST_TICK_IN_HCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_o |-> hclk_en_o); // R6
  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_o |=> !tick_en_o); // R6
  AST_STOR_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stor_en_o |=> !stor_en_o); // R6
  AST_DEV1_IN_PCLK1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|apb1_dev_en_o) |-> pclk1_en_o); // R8
  AST_DEV2_IN_PCLK2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|apb2_dev_en_o) |-> pclk2_en_o); // R8

  if (SYS_KHZ > APB1_MAX_KHZ) begin : g_ovf
    AST_OVF_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ahb_div_i[3] && !apb1_div_i[2]) |-> apb1_ovf_o); // R9
  end
endmodule

bind clk_prescale_tree clk_prescale_tree_chk #(
  .N1(N_APB1_DEV), .N2(N_APB2_DEV), .SYS_KHZ(SYS_KHZ), .APB1_MAX_KHZ(APB1_MAX_KHZ)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ahb_div_i(ahb_div_i), .apb1_div_i(apb1_div_i),
  .hclk_en_o(hclk_en_o), .pclk1_en_o(pclk1_en_o), .pclk2_en_o(pclk2_en_o),
  .tim1_en_o(tim1_en_o), .tim2_en_o(tim2_en_o), .adc_en_o(adc_en_o),
  .tick_en_o(tick_en_o), .stor_en_o(stor_en_o), .apb1_dev_en_o(apb1_dev_en_o),
  .apb2_dev_en_o(apb2_dev_en_o), .apb1_ovf_o(apb1_ovf_o)
);

// File: tb/tb_clk_prescale_tree.sv
`timescale 1ns/1ps
module tb_clk_prescale_tree;
  localparam int unsigned N1 = 4;
  localparam int unsigned N2 = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] ahb_div_i = '0;
  logic [2:0] apb1_div_i = '0, apb2_div_i = '0;
  logic [1:0] adc_div_i = '0;
  logic [N1-1:0] apb1_gate_i = '0;
  logic [N2-1:0] apb2_gate_i = '0;
  logic hclk_en_o, pclk1_en_o, pclk2_en_o, tim1_en_o, tim2_en_o;
  logic adc_en_o, tick_en_o, stor_en_o, apb1_ovf_o;
  logic [N1-1:0] apb1_dev_en_o;
  logic [N2-1:0] apb2_dev_en_o;

  always #4 clk_i = ~clk_i;

  clk_prescale_tree #(.N_APB1_DEV(N1), .N_APB2_DEV(N2), .SYS_KHZ(72000), .APB1_MAX_KHZ(36000)) dut (
    .clk_i, .rst_ni, .ahb_div_i, .apb1_div_i, .apb2_div_i, .adc_div_i,
    .apb1_gate_i, .apb2_gate_i, .hclk_en_o, .pclk1_en_o, .pclk2_en_o,
    .tim1_en_o, .tim2_en_o, .adc_en_o, .tick_en_o, .stor_en_o,
    .apb1_dev_en_o, .apb2_dev_en_o, .apb1_ovf_o
  );

  int checks = 0, fails = 0;
  bit busy = 1'b0;

  typedef struct { int id; int period; string req; } exp_t;
  exp_t exp_q[$];

  // bench-side decoding of the code tables in R2, R3, R5
  function automatic int r_ahb(input logic [3:0] c);
    int t [8] = '{2, 4, 8, 16, 64, 128, 256, 512};
    return c[3] ? t[c[2:0]] : 1;
  endfunction
  function automatic int r_apb(input logic [2:0] c);
    int t [4] = '{2, 4, 8, 16};
    return c[2] ? t[c[1:0]] : 1;
  endfunction
  function automatic int r_adc(input logic [1:0] c);
    return 2 * (int'(c) + 1);
  endfunction

  function automatic logic sig(input int id);
    case (id)
      0: return hclk_en_o;
      1: return pclk1_en_o;
      2: return pclk2_en_o;
      3: return tim1_en_o;
      4: return tim2_en_o;
      5: return adc_en_o;
      6: return tick_en_o;
      default: return stor_en_o;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver side
  task automatic set_cfg(input logic [3:0] a, input logic [2:0] b1, input logic [2:0] b2,
                         input logic [1:0] d);
    @(negedge clk_i);
    ahb_div_i = a; apb1_div_i = b1; apb2_div_i = b2; adc_div_i = d;
  endtask

  task automatic expect_p(input int id, input int p, input string req);
    exp_t e;
    e.id = id; e.period = p; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0 && !busy);
  endtask

  task automatic expect_all(input string r_main);
    int a = r_ahb(ahb_div_i), p1 = r_apb(apb1_div_i), p2 = r_apb(apb2_div_i);
    expect_p(0, a, r_main);
    expect_p(1, a * p1, "R3 pclk1");
    expect_p(2, a * p2, "R3 pclk2");
    expect_p(3, (p1 == 1) ? a : a * p1 / 2, "R4 tim1");
    expect_p(4, (p2 == 1) ? a : a * p2 / 2, "R4 tim2");
    expect_p(5, a * p2 * r_adc(adc_div_i), "R5 adc");
    expect_p(6, a * 8, "R6 tick");
    expect_p(7, a * 2, "R6 stor");
    drain();
  endtask

  // monitor: pops expected periods and times the matching strobe
  initial begin
    forever begin
      exp_t e;
      int t, last, seen, bad;
      wait (exp_q.size() > 0);
      busy = 1'b1;
      e = exp_q.pop_front();
      t = 0; last = 0; seen = 0; bad = 0;
      while (seen < 6 && t < e.period * 10 + 600) begin
        @(negedge clk_i);
        t++;
        if (sig(e.id)) begin
          if (seen >= 2 && (t - last) != e.period && bad == 0) bad = t - last;
          last = t;
          seen++;
        end
      end
      if (seen < 6) check(1'b0, e.req, seen, 6);
      else check(bad == 0, e.req, bad, e.period);
      busy = 1'b0;
    end
  end

  task automatic ovf_case(input logic [3:0] a, input logic [2:0] b);
    bit exp;
    @(negedge clk_i);
    ahb_div_i = a; apb1_div_i = b;
    #1;
    exp = 72000 > 36000 * r_ahb(a) * r_apb(b);
    check(apb1_ovf_o == exp, "R9 ovf flag", int'(apb1_ovf_o), int'(exp));
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ivl [4];
    int t, n, seen_p, bad;

    // R1: reset state
    apb1_gate_i = '1; apb2_gate_i = '1;
    repeat (3) @(negedge clk_i);
    check({hclk_en_o, pclk1_en_o, pclk2_en_o, tim1_en_o, tim2_en_o, adc_en_o,
           tick_en_o, stor_en_o} == 8'h00, "R1 strobes in reset",
          int'({hclk_en_o, pclk1_en_o, pclk2_en_o, tim1_en_o}), 0);
    check(apb1_dev_en_o == '0 && apb2_dev_en_o == '0, "R1 device strobes in reset",
          int'({apb1_dev_en_o, apb2_dev_en_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2..R6: several ratio patterns
    set_cfg(4'd0, 3'd4, 3'd0, 2'd0);
    expect_all("R2 hclk /1");
    set_cfg(4'd9, 3'd5, 3'd7, 2'd2);
    expect_all("R2 hclk /4");
    set_cfg(4'd12, 3'd0, 3'd4, 2'd1);
    expect_p(0, 64, "R2 code 12 gives /64, 32 skipped");
    expect_p(1, 64, "R3 pclk1 /1");
    expect_p(3, 64, "R4 tim1 bus ratio 1");
    expect_p(5, 512, "R5 adc /4");
    drain();
    set_cfg(4'd15, 3'd0, 3'd0, 2'd0);
    expect_p(0, 512, "R2 hclk /512");
    drain();
    set_cfg(4'd8, 3'd7, 3'd6, 2'd3);
    expect_all("R2 hclk /2");

    // R7: change from /16 to /2 mid-period
    set_cfg(4'd11, 3'd0, 3'd0, 2'd0);
    expect_p(0, 16, "R2 hclk /16");
    drain();
    do @(negedge clk_i); while (!hclk_en_o);
    repeat (5) @(negedge clk_i);
    ahb_div_i = 4'd8;
    t = 5; n = 0;
    while (n < 4 && t < 200) begin
      @(negedge clk_i);
      t++;
      if (hclk_en_o) begin ivl[n] = t; n++; t = 0; end
    end
    check(n == 4 && ivl[0] == 16, "R7 period in progress keeps old length", ivl[0], 16);
    check(n == 4 && ivl[1] == 2 && ivl[2] == 2 && ivl[3] == 2, "R7 new length after boundary",
          ivl[1], 2);

    // R8: per-device gates
    set_cfg(4'd0, 3'd4, 3'd5, 2'd0);
    apb1_gate_i = 4'b0101; apb2_gate_i = 4'b1000;
    repeat (20) @(negedge clk_i);
    seen_p = 0; bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (pclk1_en_o) seen_p++;
      if (apb1_dev_en_o != ({4{pclk1_en_o}} & 4'b0101)) bad++;
      if (apb2_dev_en_o != ({4{pclk2_en_o}} & 4'b1000)) bad++;
    end
    check(seen_p > 0, "R8 bus 1 active during gate window", seen_p, 20);
    check(bad == 0, "R8 gated strobes follow enable bits", bad, 0);
    apb1_gate_i = '0; apb2_gate_i = '0;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (apb1_dev_en_o != '0 || apb2_dev_en_o != '0) bad++;
    end
    check(bad == 0, "R8 cleared gates hold strobes low", bad, 0);

    // R9: over-frequency flag
    ovf_case(4'd0, 3'd0);
    ovf_case(4'd0, 3'd4);
    ovf_case(4'd8, 3'd0);
    ovf_case(4'd11, 3'd7);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule